// File: doc/BRIEF.md
# Dual I/O Window Address Decoder

This block sits between a host I/O bus and a removable card slot. Software programs two I/O windows through a small byte-wide register port. Each window has a 16-bit start address, an inclusive 16-bit stop address, an enable bit and a 4-bit option nibble. The register port uses one index, write data and a combinational read-back.

On each cycle where the I/O strobe is high, the block compares the bus address against both windows and registers the result. The result gives whether a window claimed the access, which window it was, a one-hot card select, and the access options of the claiming window: data width, zero-wait request and timing-set choice. The data width can be fixed by software. It can also follow the card's 16-bit-decode response, which arrives on an input pin in the same cycle as the address.

The decode results appear one clock after the strobe cycle. A register write takes effect at the same clock edge, so an access in the same cycle as a write is decoded with the values held before that write.

Top module: `io_window_decoder`

## Requirements
- R1: After reset every register reads 0 and all decode outputs (`io_hit`, `hit_win`, `card_sel`, `wide16`, `zero_wait`, `timing_sel`) are 0.
- R2: A write at index 0x06 (enables), 0x07 (option nibbles) or 0x08..0x0F updates that byte at the next clock, and `reg_rdata` returns the stored byte of the index it is given. The window bytes are laid out as follows: window n starts at base 0x08+4n, with the start at base+0/base+1 and the stop at base+2/base+3, low byte first. Every other index reads 0 and ignores writes.
- R3: Window n claims an access when bit 6+n of index 0x06 is set and start ≤ address ≤ stop. Both the start and the stop address hit. A window whose enable bit is clear never hits.
- R4: A window whose start address is greater than its stop address never hits.
- R5: When both windows contain the address, window 0 is reported (`hit_win`=0, `card_sel`=2'b01). `card_sel` is one-hot for the winning window (bit n for window n) and zero on a miss.
- R6: Decode outputs are registered and valid the clock after the cycle with `io_strobe` high. A cycle without strobe yields all outputs 0 at the next clock.
- R7: When option bit 1 of the winning window is set, `wide16` equals `card_iocs16` from the strobe cycle. Otherwise it equals option bit 0.
- R8: `zero_wait` is option bit 2 and `timing_sel` is option bit 3 of the winning window. On a miss, `wide16`, `zero_wait` and `timing_sel` are 0.
- R9: Window 0 takes its options from bits 3:0 of index 0x07 and window 1 from bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for write and read-back |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the register at `reg_idx` |
| io_strobe | input | 1 | Bus I/O access valid this cycle |
| io_addr | input | 16 | Bus I/O address |
| card_iocs16 | input | 1 | Card reports 16-bit decode for this access |
| io_hit | output | 1 | A window claimed the previous strobed access |
| hit_win | output | 1 | Number of the claiming window |
| card_sel | output | 2 | One-hot select of the claiming window |
| wide16 | output | 1 | Use a 16-bit data path |
| zero_wait | output | 1 | Zero-wait-state request |
| timing_sel | output | 1 | Timing register set to use |

## Verification
Three situations are hard to reach by chance. One is an access in the same cycle as a write to the window that the access touches. Another is an address inside two enabled, overlapping windows. The third is an inverted window, whose start is above its stop. Directed sequences build overlapping windows and an inverted window, then probe each start and stop address and its neighbours. A long random phase then mixes register writes with accesses, and about half of the addresses are drawn near the programmed bounds. A behavioural model compares reads and decode results on every clock.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
    localparam int WIN_COUNT = 2;
    localparam int WIN_IDX_W = (WIN_COUNT > 1) ? $clog2(WIN_COUNT) : 1;
    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 8;
    localparam int NIB_W     = 4;
    localparam int BYTES_PER_ADDR = ADDR_W / BYTE_W;
    localparam int SLOTS_PER_WIN  = 2 * BYTES_PER_ADDR;
    localparam int EN_BIT_BASE    = 6;

    localparam logic [IDX_W-1:0] IDX_ENABLE   = 8'h06;
    localparam logic [IDX_W-1:0] IDX_OPTIONS  = 8'h07;
    localparam logic [IDX_W-1:0] IDX_WIN_BASE = 8'h08;

    // option nibble bit positions
    localparam int OPT_FIX16 = 0;
    localparam int OPT_CARD16 = 1;
    localparam int OPT_ZWS = 2;
    localparam int OPT_TSET = 3;

    typedef struct packed {
        logic [WIN_COUNT-1:0][ADDR_W-1:0] lo;
        logic [WIN_COUNT-1:0][ADDR_W-1:0] hi;
        logic [BYTE_W-1:0]                en;
        logic [BYTE_W-1:0]                opt;
    } win_regs_t;

    typedef struct packed {
        logic                 hit;
        logic [WIN_IDX_W-1:0] win;
        logic [WIN_COUNT-1:0] sel;
        logic                 wide;
        logic                 zws;
        logic                 tset;
    } dec_out_t;
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
    import io_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output win_regs_t         regs
);
    win_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        if (idx == IDX_ENABLE) begin
            rdata = regs_q.en;
            if (wr_en) regs_d.en = wdata;
        end
        if (idx == IDX_OPTIONS) begin
            rdata = regs_q.opt;
            if (wr_en) regs_d.opt = wdata;
        end
        for (int w = 0; w < WIN_COUNT; w++) begin
            for (int b = 0; b < BYTES_PER_ADDR; b++) begin
                if (idx == IDX_W'(int'(IDX_WIN_BASE) + SLOTS_PER_WIN*w + b)) begin
                    rdata = regs_q.lo[w][BYTE_W*b +: BYTE_W];
                    if (wr_en) regs_d.lo[w][BYTE_W*b +: BYTE_W] = wdata;
                end
                if (idx == IDX_W'(int'(IDX_WIN_BASE) + SLOTS_PER_WIN*w + BYTES_PER_ADDR + b)) begin
                    rdata = regs_q.hi[w][BYTE_W*b +: BYTE_W];
                    if (wr_en) regs_d.hi[w][BYTE_W*b +: BYTE_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R2: an option write is visible one clock later
    assert_opt_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_OPTIONS) |=> (regs_q.opt == $past(wdata)));
    // R2: unmapped indices read zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx < IDX_ENABLE || idx >= IDX_W'(int'(IDX_WIN_BASE) + SLOTS_PER_WIN*WIN_COUNT))
        |-> (rdata == '0));
endmodule

// File: rtl/io_win_match.sv
module io_win_match
    import io_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              match
);
    always_comb begin
        match = enable && (addr >= lo) && (addr <= hi);
    end

    // R4: an inverted window claims nothing
    assert_inverted_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo > hi) |-> !match);
    // R3: a disabled window claims nothing
    assert_disabled_nohit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !match);
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import io_win_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic                 io_strobe,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 card_iocs16,
    output logic                 io_hit,
    output logic [WIN_IDX_W-1:0] hit_win,
    output logic [WIN_COUNT-1:0] card_sel,
    output logic                 wide16,
    output logic                 zero_wait,
    output logic                 timing_sel
);
    win_regs_t             regs;
    logic [WIN_COUNT-1:0]  win_match;
    logic [NIB_W-1:0]      win_opt [WIN_COUNT];
    dec_out_t              out_d, out_q;

    io_win_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_we),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .regs  (regs)
    );

    for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
        io_win_match u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (regs.en[EN_BIT_BASE + w]),
            .addr   (io_addr),
            .lo     (regs.lo[w]),
            .hi     (regs.hi[w]),
            .match  (win_match[w])
        );
        assign win_opt[w] = regs.opt[NIB_W*w +: NIB_W];
    end

    always_comb begin
        logic [NIB_W-1:0] opt_sel;
        out_d   = '0;
        opt_sel = '0;
        if (io_strobe) begin
            // descending scan: lowest-numbered match is assigned last and wins
            for (int w = WIN_COUNT - 1; w >= 0; w--) begin
                if (win_match[w]) begin
                    out_d.hit = 1'b1;
                    out_d.win = WIN_IDX_W'(w);
                    out_d.sel = WIN_COUNT'(1) << w;
                    opt_sel   = win_opt[w];
                end
            end
            if (out_d.hit) begin
                out_d.wide = opt_sel[OPT_CARD16] ? card_iocs16 : opt_sel[OPT_FIX16];
                out_d.zws  = opt_sel[OPT_ZWS];
                out_d.tset = opt_sel[OPT_TSET];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign io_hit     = out_q.hit;
    assign hit_win    = out_q.win;
    assign card_sel   = out_q.sel;
    assign wide16     = out_q.wide;
    assign zero_wait  = out_q.zws;
    assign timing_sel = out_q.tset;

    // R6: no strobe, no hit on the next clock
    assert_idle_nohit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strobe |=> !io_hit);
    // R5: at most one card select
    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(card_sel));
    // R5: window 0 wins whenever it matches a strobed address
    assert_win0_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && win_match[0]) |=> (io_hit && hit_win == '0 && card_sel[0]));
    // R8: options are quiet on a miss
    assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> !(wide16 || zero_wait || timing_sel));
    // R3: hit and card select agree
    assert_hit_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit == (card_sel != '0));
endmodule

// File: tb/test_io_window_decoder.sv
module test_io_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        io_strobe = 1'b0;
    logic [15:0] io_addr = '0;
    logic        card_iocs16 = 1'b0;
    logic        io_hit;
    logic [0:0]  hit_win;
    logic [1:0]  card_sel;
    logic        wide16, zero_wait, timing_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    io_window_decoder i_io_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_strobe(io_strobe),
        .io_addr(io_addr), .card_iocs16(card_iocs16), .io_hit(io_hit),
        .hit_win(hit_win), .card_sel(card_sel), .wide16(wide16),
        .zero_wait(zero_wait), .timing_sel(timing_sel)
    );

    // behavioural model: a plain byte store
    logic [7:0] mreg [0:15];

    function automatic logic [7:0] m_read(input logic [7:0] i);
        if (i >= 8'h06 && i <= 8'h0F) return mreg[i[3:0]];
        return 8'h00;
    endfunction

    function automatic logic [15:0] m_start(input int w);
        return {mreg[9 + 4*w], mreg[8 + 4*w]};
    endfunction

    function automatic logic [15:0] m_stop(input int w);
        return {mreg[11 + 4*w], mreg[10 + 4*w]};
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] idx, input logic [7:0] wd,
                        input bit stb, input logic [15:0] addr, input bit cs16);
        int    ew;
        bit    ehit, ewide, ezws, etim, inverted;
        logic [3:0] nib;
        string tag;
        reg_we = we; reg_idx = idx; reg_wdata = wd;
        io_strobe = stb; io_addr = addr; card_iocs16 = cs16;
        #1;
        check("R2", "rdata", reg_rdata, m_read(idx));
        ehit = 1'b0; ew = 0; inverted = 1'b0;
        for (int w = 1; w >= 0; w--) begin
            if (m_start(w) > m_stop(w)) inverted = 1'b1;
            if (stb && mreg[6][6+w] && addr >= m_start(w) && addr <= m_stop(w)) begin
                ehit = 1'b1; ew = w;
            end
        end
        nib   = ew == 0 ? mreg[7][3:0] : mreg[7][7:4];
        ewide = ehit && (nib[1] ? cs16 : nib[0]);
        ezws  = ehit && nib[2];
        etim  = ehit && nib[3];
        tag = !stb ? "R6" : (inverted ? "R4" : "R3");
        @(posedge clk);
        if (we && idx >= 8'h06 && idx <= 8'h0F) mreg[idx[3:0]] = wd;
        @(negedge clk);
        check(tag, "io_hit", io_hit, ehit);
        check("R5", "hit_win", hit_win, ehit ? ew : 0);
        check("R5", "card_sel", card_sel, ehit ? (1 << ew) : 0);
        check("R7", "wide16", wide16, ewide);
        check(ew == 1 ? "R9" : "R8", "zero_wait", zero_wait, ezws);
        check(ew == 1 ? "R9" : "R8", "timing_sel", timing_sel, etim);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        step(1'b1, idx, d, 1'b0, 16'h0000, 1'b0);
    endtask

    task automatic set_win(input int w, input logic [15:0] s, input logic [15:0] e);
        wr(8'(8 + 4*w), s[7:0]);  wr(8'(9 + 4*w), s[15:8]);
        wr(8'(10 + 4*w), e[7:0]); wr(8'(11 + 4*w), e[15:8]);
    endtask

    task automatic acc(input logic [15:0] a, input bit cs16);
        step(1'b0, 8'h07, 8'h00, 1'b1, a, cs16);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "io_hit", io_hit, 0);
        check("R1", "card_sel", card_sel, 0);
        for (int i = 6; i < 16; i++) begin
            reg_idx = 8'(i); #1;
            check("R1", "reset read", reg_rdata, 0);
        end
        set_win(0, 16'h0300, 16'h031F);
        set_win(1, 16'h0310, 16'h0400);
        wr(8'h06, 8'hC0);
        wr(8'h07, 8'h5A);                 // R9: w0 nibble A, w1 nibble 5
        // R3 boundaries, R5 overlap, R7 card width follow
        acc(16'h02FF, 1'b1); acc(16'h0300, 1'b1); acc(16'h0300, 1'b0);
        acc(16'h031F, 1'b1); acc(16'h0310, 1'b0); acc(16'h0320, 1'b1);
        acc(16'h0400, 1'b0); acc(16'h0401, 1'b1);
        // R6: no strobe on a claimed address
        step(1'b0, 8'h07, 8'h00, 1'b0, 16'h0305, 1'b1);
        // R3: only window 1 enabled
        wr(8'h06, 8'h80);
        acc(16'h0305, 1'b0); acc(16'h0310, 1'b1);
        // R4: inverted window 0
        wr(8'h06, 8'hC0);
        set_win(0, 16'h0500, 16'h04FF);
        acc(16'h04FF, 1'b0); acc(16'h0500, 1'b0); acc(16'h0400, 1'b0);
        // R2: unmapped indices ignore writes
        wr(8'h05, 8'hFF); wr(8'h10, 8'hAA); wr(8'h3F, 8'h55);
        step(1'b0, 8'h10, 8'h00, 1'b0, 16'h0, 1'b0);
        // access in the same cycle as a write to its window
        step(1'b1, 8'h08, 8'h00, 1'b1, 16'h0300, 1'b1);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            bit          we;
            logic [7:0]  idx;
            logic [15:0] a;
            int          w;
            we  = ($urandom % 4) == 0;
            idx = ($urandom % 8 == 0) ? 8'($urandom % 64) : 8'(6 + $urandom % 10);
            w   = $urandom % 2;
            case ($urandom % 4)
                0: a = m_start(w) + 16'($urandom % 3) - 16'd1;
                1: a = m_stop(w) + 16'($urandom % 3) - 16'd1;
                default: a = 16'($urandom);
            endcase
            step(we, idx, 8'($urandom), ($urandom % 4) != 0, a, 1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule